// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches. Two predictors run side by side. A correlating predictor keys its counters on the recent outcomes of all branches, combined with the branch address. A local predictor keys its counters on the recent outcomes of the same branch only. A per-address chooser table decides which of the two predictions is used. A fetch stage presents a branch address on the lookup port. In the same cycle it gets the final direction and the two component directions, and it keeps the component directions alongside the branch.

When the branch resolves, the back end presents the address, the real outcome and the two component directions saved at lookup time on the update port. Within one clock edge the predictor trains the chosen counters, shifts both histories and adjusts the chooser. Lookups always see the state from before any update that happens in the same cycle.

Top module: `tourney_dirpred`

## Requirements
- R1: After reset, every counter holds 1 (weakly not-taken), both histories are zero and every chooser entry holds 1. A lookup of any address then returns 0 on all three prediction outputs.
- R2: Every prediction counter is 2 bits wide and ranges from 0 to 3. It predicts taken when its value is 2 or more. A taken outcome raises it and a not-taken outcome lowers it, and it saturates at 3 and at 0. From a saturated value, the prediction changes only after two opposite outcomes in a row.
- R3: The global history is a HIST_W-bit shift register. On each update it shifts left, and the outcome enters bit 0 (1 = taken).
- R4: The correlating counter is selected by the global history XOR address bits [ALIGN+HIST_W-1:ALIGN].
- R5: The local history table is indexed by address bits [ALIGN+LHT_BITS-1:ALIGN], and each entry holds HIST_W outcome bits. The local counter is selected by the history read from that entry. An update shifts the outcome into bit 0 of that entry.
- R6: The chooser is indexed by address bits [ALIGN+CH_BITS-1:ALIGN]. Values 0 and 1 select the correlating prediction, and values 2 and 3 select the local prediction. The entry moves one step toward the component that matched the outcome, and only when exactly one of the two components matched.
- R7: The lookup outputs are combinational in the lookup address. When a lookup and an update touch the same entries in one cycle, the lookup returns the values from before the update.
- R8: While up_valid is low, no counter, history or chooser entry changes, so repeated lookups return the same predictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Lookup branch address |
| lk_taken | output | 1 | Final predicted direction |
| lk_glob_pred | output | 1 | Correlating component direction |
| lk_loc_pred | output | 1 | Local component direction |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_glob_pred | input | 1 | Correlating direction saved at lookup |
| up_loc_pred | input | 1 | Local direction saved at lookup |

## Verification
The properties assume two things about the inputs: lk_pc holds its value between clock edges, and up_glob_pred and up_loc_pred carry the directions that were returned for that branch, so that the chooser training is meaningful. The stimulus keeps within this. Each branch is looked up and resolved in the same cycle, and the driver feeds the component directions just produced back on the update port. The stimulus also inserts idle cycles with a steady address so that the hold properties are exercised.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CHOOSE_WEAK_G = 2'b01;

    // saturating step: up=1 counts toward 3, up=0 toward 0
    function automatic ctr_t ctr_step(ctr_t c, logic up);
        if (up) return (c == 2'b11) ? c : ctr_t'(c + 2'd1);
        else    return (c == 2'b00) ? c : ctr_t'(c - 2'd1);
    endfunction

endpackage

// File: rtl/dirpred_global.sv
module dirpred_global
    import dirpred_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] lk_idx,
    output logic              lk_pred,
    input  logic              up_valid,
    input  logic [HIST_W-1:0] up_idx,
    input  logic              up_taken,
    output logic [HIST_W-1:0] hist_o
);
    localparam int N = 1 << HIST_W;

    typedef struct packed {
        logic [HIST_W-1:0]  hist;
        logic [N-1:0][1:0]  cnt;
    } gstate_t;

    localparam gstate_t RST = '{hist: '0, cnt: {N{CTR_WEAK_NT}}};

    gstate_t st_d, st_q;
    logic [HIST_W-1:0] rd_sel, wr_sel;

    assign rd_sel = st_q.hist ^ lk_idx;
    assign wr_sel = st_q.hist ^ up_idx;

    always_comb begin
        st_d = st_q;
        if (up_valid) begin
            st_d.cnt[wr_sel] = ctr_step(st_q.cnt[wr_sel], up_taken);
            st_d.hist        = {st_q.hist[HIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign lk_pred = st_q.cnt[rd_sel][1];
    assign hist_o  = st_q.hist;
endmodule

// File: rtl/dirpred_local.sv
module dirpred_local
    import dirpred_pkg::*;
#(
    parameter int HIST_W   = 4,
    parameter int LHT_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LHT_BITS-1:0] lk_idx,
    output logic                lk_pred,
    input  logic                up_valid,
    input  logic [LHT_BITS-1:0] up_idx,
    input  logic                up_taken
);
    localparam int NH = 1 << LHT_BITS;
    localparam int NC = 1 << HIST_W;

    typedef struct packed {
        logic [NH-1:0][HIST_W-1:0] hist;
        logic [NC-1:0][1:0]        cnt;
    } lstate_t;

    localparam lstate_t RST = '{hist: '0, cnt: {NC{CTR_WEAK_NT}}};

    lstate_t st_d, st_q;
    logic [HIST_W-1:0] rd_hist, wr_hist;

    assign rd_hist = st_q.hist[lk_idx];
    assign wr_hist = st_q.hist[up_idx];

    always_comb begin
        st_d = st_q;
        if (up_valid) begin
            st_d.cnt[wr_hist]  = ctr_step(st_q.cnt[wr_hist], up_taken);
            st_d.hist[up_idx]  = {wr_hist[HIST_W-2:0], up_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign lk_pred = st_q.cnt[rd_hist][1];
endmodule

// File: rtl/dirpred_chooser.sv
module dirpred_chooser
    import dirpred_pkg::*;
#(
    parameter int CH_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CH_BITS-1:0] lk_idx,
    output logic               lk_use_loc,
    input  logic               up_valid,
    input  logic [CH_BITS-1:0] up_idx,
    input  logic               up_taken,
    input  logic               up_glob_pred,
    input  logic               up_loc_pred
);
    localparam int N = 1 << CH_BITS;

    typedef struct packed {
        logic [N-1:0][1:0] sel;
    } cstate_t;

    localparam cstate_t RST = '{sel: {N{CHOOSE_WEAK_G}}};

    cstate_t st_d, st_q;
    logic g_ok, l_ok;

    assign g_ok = (up_glob_pred == up_taken);
    assign l_ok = (up_loc_pred  == up_taken);

    always_comb begin
        st_d = st_q;
        if (up_valid && (g_ok != l_ok)) begin
            // toward local when only local matched, toward global otherwise
            st_d.sel[up_idx] = ctr_step(st_q.sel[up_idx], l_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign lk_use_loc = st_q.sel[lk_idx][1];
endmodule

// File: rtl/tourney_dirpred.sv
module tourney_dirpred
    import dirpred_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int ALIGN    = 2,
    parameter int HIST_W   = 4,
    parameter int LHT_BITS = 4,
    parameter int CH_BITS  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_glob_pred,
    output logic            lk_loc_pred,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_glob_pred,
    input  logic            up_loc_pred
);
    logic              use_loc;
    logic [HIST_W-1:0] ghist;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{lk_pc, up_pc};

    dirpred_global #(.HIST_W(HIST_W)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_pc[ALIGN +: HIST_W]),
        .lk_pred  (lk_glob_pred),
        .up_valid (up_valid),
        .up_idx   (up_pc[ALIGN +: HIST_W]),
        .up_taken (up_taken),
        .hist_o   (ghist)
    );

    dirpred_local #(.HIST_W(HIST_W), .LHT_BITS(LHT_BITS)) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_pc[ALIGN +: LHT_BITS]),
        .lk_pred  (lk_loc_pred),
        .up_valid (up_valid),
        .up_idx   (up_pc[ALIGN +: LHT_BITS]),
        .up_taken (up_taken)
    );

    dirpred_chooser #(.CH_BITS(CH_BITS)) u_choose (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_idx       (lk_pc[ALIGN +: CH_BITS]),
        .lk_use_loc   (use_loc),
        .up_valid     (up_valid),
        .up_idx       (up_pc[ALIGN +: CH_BITS]),
        .up_taken     (up_taken),
        .up_glob_pred (up_glob_pred),
        .up_loc_pred  (up_loc_pred)
    );

    assign lk_taken = use_loc ? lk_loc_pred : lk_glob_pred;
endmodule

// File: rtl/tourney_dirpred_chk.sv
module tourney_dirpred_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic              lk_glob_pred,
    input logic              lk_loc_pred,
    input logic              up_valid,
    input logic              up_taken,
    input logic [HIST_W-1:0] ghist
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: first cycle out of reset predicts not-taken everywhere
    p_reset_nt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (!lk_taken && !lk_glob_pred && !lk_loc_pred));

    // R3: history shifts the resolved outcome into bit 0
    p_ghist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(up_valid)) |->
            (ghist == {$past(ghist[HIST_W-2:0]), $past(up_taken)}));

    // R6: when both components agree the final direction follows them
    p_agree_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred));

    // R8: no update, steady address -> steady predictions
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(up_valid) && $stable(lk_pc)) |->
            $stable({lk_taken, lk_glob_pred, lk_loc_pred}));

    // R8: history frozen without update
    p_ghist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(up_valid)) |-> $stable(ghist));
endmodule

bind tourney_dirpred tourney_dirpred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .lk_taken     (lk_taken),
    .lk_glob_pred (lk_glob_pred),
    .lk_loc_pred  (lk_loc_pred),
    .up_valid     (up_valid),
    .up_taken     (up_taken),
    .ghist        (ghist)
);

// File: tb/tourney_dirpred_tb_top.sv
`timescale 1ns/1ps
module tourney_dirpred_tb_top;
    localparam int PC_W = 32;
    localparam int HW   = 4;   // history width, also table index widths
    localparam int NT   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
    logic up_valid = 1'b0, up_taken = 1'b0, up_glob_pred = 1'b0, up_loc_pred = 1'b0;
    logic lk_taken, lk_glob_pred, lk_loc_pred;

    always #5 clk = ~clk;

    tourney_dirpred dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred)
    );

    // reference state, built from the requirements
    int m_gc[NT], m_lc[NT], m_lh[NT], m_ch[NT];
    int m_gh;

    typedef struct { logic [2:0] exp; string tag; } item_t;
    item_t sb_q[$];
    event  ev_drv;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    function automatic int sat(int c, bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // drive one lookup (and optionally the update of the same branch)
    task automatic step(input logic [PC_W-1:0] pc, input bit tk, input bit upd, input string tag);
        int ix, gsel, lh;
        bit g, l, f;
        item_t it;
        @(negedge clk);
        ix   = int'(pc[5:2]);
        gsel = (m_gh ^ ix) & (NT - 1);
        lh   = m_lh[ix];
        g = (m_gc[gsel] >= 2);
        l = (m_lc[lh] >= 2);
        f = (m_ch[ix] >= 2) ? l : g;
        it.exp = {f, g, l};
        it.tag = tag;
        sb_q.push_back(it);
        lk_pc = pc; up_pc = pc; up_valid = upd; up_taken = tk;
        up_glob_pred = g; up_loc_pred = l;
        -> ev_drv;
        @(posedge clk);
        if (upd) begin
            m_gc[gsel] = sat(m_gc[gsel], tk);
            m_lc[lh]   = sat(m_lc[lh], tk);
            m_lh[ix]   = ((lh << 1) | int'(tk)) & (NT - 1);
            m_gh       = ((m_gh << 1) | int'(tk)) & (NT - 1);
            if ((g == tk) != (l == tk)) m_ch[ix] = sat(m_ch[ix], l == tk);
        end
    endtask

    // monitor: compare design outputs with the queued expectation
    initial begin
        forever begin
            @(ev_drv);
            #1;
            begin
                item_t it;
                logic [2:0] act;
                it  = sb_q.pop_front();
                act = {lk_taken, lk_glob_pred, lk_loc_pred};
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: {final,glob,loc} actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NT; i++) begin
            m_gc[i] = 1; m_lc[i] = 1; m_lh[i] = 0; m_ch[i] = 1;
        end
        m_gh = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state seen at several addresses
        step(32'h0000_0000, 0, 0, "R1");
        step(32'h0000_003C, 0, 0, "R1");
        step(32'h1234_5678, 0, 0, "R1");

        // R2: saturate up, then two not-taken to flip (R7: same-cycle updates)
        for (int k = 0; k < 5; k++) step(32'h0000_0040, 1, 1, "R2 R7");
        for (int k = 0; k < 4; k++) step(32'h0000_0040, 0, 1, "R2");

        // R8: idle cycles, repeated lookup must not move
        for (int k = 0; k < 6; k++) step(32'h0000_0044, 1, 0, "R8");

        // R3 R4: alternating pattern across addresses exercises history XOR index
        for (int k = 0; k < 40; k++) step(32'h100 + 4 * (k % 3), k[0], 1, "R3 R4");

        // R5: one branch with a period-3 pattern the local side learns
        for (int k = 0; k < 48; k++) step(32'h0000_0018, (k % 3) != 2, 1, "R5");

        // R6: interleaved branches with differing behaviour train the chooser
        for (int k = 0; k < 60; k++) begin
            step(32'h0000_0020, (k % 4) == 0, 1, "R6");
            step(32'h0000_0024, 1, 1, "R6");
        end

        // mixed pseudo-random traffic with occasional idle cycles
        lfsr = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step({22'd0, lfsr[7:0], 2'b00}, lfsr[9] | lfsr[3], lfsr[11:10] != 2'b00, "R5 R6 R8");
        end

        @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule